// File: doc/BRIEF.md
# Contactless Card Value-Block Engine

This block is the tag-side engine for the value-block operations of a 1 KB contactless memory card. It owns a memory of 64 blocks of 16 bytes, grouped as 16 sectors of 4 blocks. It takes already decoded command frames for decrement, increment, restore and transfer. Arithmetic never touches memory directly. Decrement, increment and restore place their result in a volatile working register. A separate transfer command commits that register to a block.

Each operation is checked against three conditions. The sector must carry its authentication flag, the block's three access bits must select a value-block mode, and the block must not be block 0 or a sector trailer. A value block holds a signed 32-bit value three times: plain, inverted, then plain again. Any operation on a block whose copies do not agree is refused.

Replies are 4-bit codes on a one-cycle response strobe. A separate load port and a read port connect the block memory to the card's plain read and write handler.

Top module: `vb_engine`

## Requirements
- R1: After reset `rsp_valid` is low, no two-step operation is pending, and the volatile register is empty. A transfer issued before any successful arithmetic step is answered 0x1.
- R2: A first-step frame carries the opcode on `frm_cmd` and the block address on `frm_arg[7:0]`. The 4-bit reply appears on `rsp_code` with `rsp_valid` high for exactly the one cycle after the frame's clock edge. 0xA is the ACK code. An opcode other than 0xC0, 0xC1, 0xC2 or 0xB0 is answered 0x1.
- R3: Increment (0xC1) is acknowledged with 0xA on its first step. Its second frame carries a 32-bit operand on `frm_arg`. That frame gets no reply, and it sets the volatile register to the block value plus the operand. The stored block does not change.
- R4: Decrement (0xC0) follows the same two steps as increment and sets the volatile register to the block value minus the operand.
- R5: Restore (0xC2) is acknowledged on its first step. Its second frame gets no reply and copies the block value into the volatile register. The operand is ignored.
- R6: Transfer (0xB0) writes the volatile value to bits [31:0] and [95:64] of the addressed block, and its inverse to bits [63:32]. Bits [127:96] are kept. The ACK is sent in the same cycle that the new contents appear on `rd_data`.
- R7: An operation on block n is answered 0x4 and changes nothing unless `auth_sector[n/4]` is 1.
- R8: The access bits of block n are `acc_bits[3n+2:3n]` = {C1,C2,C3}. Any value other than 3'b110 or 3'b001 is answered 0x4.
- R9: Block 0, every sector trailer (n mod 4 = 3) and every address of 64 or more are answered 0x4, whatever their flags say.
- R10: An operation on a block whose bits [31:0], [63:32] and [95:64] are not value, inverted value, value is answered 0x1. For transfer, this check applies to the target block. The 0x4 checks take precedence.
- R11: An increment or decrement whose signed 32-bit result overflows answers its second frame with 0x1 and leaves the volatile register as it was.
- R12: While `card_active` is low or no sector is authenticated, frames get no reply, a pending first step is dropped and the volatile register is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_active | input | 1 | Card is selected and active |
| auth_sector | input | 16 | Authenticated flag, one bit per sector |
| acc_bits | input | 192 | Access bits {C1,C2,C3} per block, block n at [3n+2:3n] |
| frm_valid | input | 1 | Decoded frame strobe |
| frm_cmd | input | 8 | Opcode of a first-step frame |
| frm_arg | input | 32 | Block address in [7:0] on a first step, operand on a second step |
| rsp_valid | output | 1 | Reply strobe |
| rsp_code | output | 4 | 4-bit ACK/NAK code |
| ld_valid | input | 1 | Block load strobe from the plain write path |
| ld_block | input | 6 | Block index to load |
| ld_data | input | 128 | Block contents to load |
| rd_block | input | 6 | Block index to read |
| rd_data | output | 128 | Contents of the block selected by rd_block |

## Verification
The bench builds the engine with its default parameters: 16 sectors of 4 blocks and a 32-bit value. With these values the highest sector's last data block (62) and its trailer (63) can be tested, and so can address 64, the first one out of range. The 32-bit width makes the signed limits 0x7FFFFFFF and 0x80000000 reachable with an operand of 1. This exercises the overflow refusal in both directions.

// File: rtl/vb_pkg.sv
`timescale 1ns/1ps
package vb_pkg;
    localparam logic [7:0] OPC_DEC = 8'hC0;
    localparam logic [7:0] OPC_INC = 8'hC1;
    localparam logic [7:0] OPC_RST = 8'hC2;
    localparam logic [7:0] OPC_XFR = 8'hB0;

    localparam logic [3:0] RSP_ACK      = 4'hA;
    localparam logic [3:0] RSP_NAK_DENY = 4'h4;
    localparam logic [3:0] RSP_NAK_BAD  = 4'h1;

    typedef enum logic [1:0] {ARITH_PASS, ARITH_ADD, ARITH_SUB} arith_e;
    typedef enum logic {PH_IDLE, PH_OPERAND} phase_e;
endpackage

// File: rtl/vb_access_check.sv
`timescale 1ns/1ps
module vb_access_check #(
    parameter int NUM_SECTORS       = 16,
    parameter int BLOCKS_PER_SECTOR = 4,
    localparam int NUM_BLOCKS       = NUM_SECTORS * BLOCKS_PER_SECTOR,
    localparam int BLK_W            = $clog2(NUM_BLOCKS)
) (
    input  logic [7:0]              blk_addr,
    input  logic [NUM_SECTORS-1:0]  auth_sector,
    input  logic [NUM_BLOCKS*3-1:0] acc_bits,
    output logic                    permit
);
    logic [NUM_BLOCKS-1:0] allow_vec;

    // One permission bit per block: sector authenticated, value-block access
    // code, and neither block 0 nor a trailer.
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        localparam int  SEC      = b / BLOCKS_PER_SECTOR;
        localparam bit  FIXED_OK = (b != 0) && ((b % BLOCKS_PER_SECTOR) != BLOCKS_PER_SECTOR - 1);
        logic [2:0] code;
        assign code         = acc_bits[3*b +: 3];
        assign allow_vec[b] = FIXED_OK && auth_sector[SEC] &&
                              ((code == 3'b110) || (code == 3'b001));
    end

    always_comb begin
        permit = 1'b0;
        if (32'(blk_addr) < NUM_BLOCKS)
            permit = allow_vec[blk_addr[BLK_W-1:0]];
    end
endmodule

// File: rtl/vb_value_alu.sv
`timescale 1ns/1ps
module vb_value_alu
    import vb_pkg::*;
#(
    parameter int VALUE_W = 32,
    localparam int BLOCK_BITS = 4 * VALUE_W
) (
    input  logic [BLOCK_BITS-1:0] blk_data,
    input  logic [VALUE_W-1:0]    operand,
    input  arith_e                mode,
    output logic                  fmt_ok,
    output logic [VALUE_W-1:0]    result,
    output logic                  ovf
);
    logic [VALUE_W-1:0] v0, v1, v2, sum, diff;

    always_comb begin
        v0   = blk_data[VALUE_W-1:0];
        v1   = blk_data[2*VALUE_W-1:VALUE_W];
        v2   = blk_data[3*VALUE_W-1:2*VALUE_W];
        fmt_ok = (v0 == v2) && (v1 == ~v0);
        sum  = v0 + operand;
        diff = v0 - operand;
        case (mode)
            ARITH_ADD: begin
                result = sum;
                ovf    = (v0[VALUE_W-1] == operand[VALUE_W-1]) &&
                         (sum[VALUE_W-1] != v0[VALUE_W-1]);
            end
            ARITH_SUB: begin
                result = diff;
                ovf    = (v0[VALUE_W-1] != operand[VALUE_W-1]) &&
                         (diff[VALUE_W-1] != v0[VALUE_W-1]);
            end
            default: begin
                result = v0;
                ovf    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vb_block_mem.sv
`timescale 1ns/1ps
module vb_block_mem #(
    parameter int NUM_BLOCKS        = 64,
    parameter int BLOCKS_PER_SECTOR = 4,
    parameter int BLOCK_BITS        = 128,
    localparam int BLK_W            = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_we,
    input  logic [BLK_W-1:0]      ld_blk,
    input  logic [BLOCK_BITS-1:0] ld_data,
    input  logic                  xf_we,
    input  logic [BLK_W-1:0]      xf_blk,
    input  logic [BLOCK_BITS-1:0] xf_data,
    input  logic [BLK_W-1:0]      rda_blk,
    output logic [BLOCK_BITS-1:0] rda_data,
    input  logic [BLK_W-1:0]      rdb_blk,
    output logic [BLOCK_BITS-1:0] rdb_data
);
    logic [BLOCK_BITS-1:0] mem_d [NUM_BLOCKS];
    logic [BLOCK_BITS-1:0] mem_q [NUM_BLOCKS];

    always_comb begin
        mem_d = mem_q;
        if (xf_we) mem_d[xf_blk] = xf_data;
        if (ld_we) mem_d[ld_blk] = ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BLOCKS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rda_data = mem_q[rda_blk];
    assign rdb_data = mem_q[rdb_blk];

    // R9
    xfer_target_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xf_we |-> ((xf_blk != '0) &&
                   ((32'(xf_blk) % BLOCKS_PER_SECTOR) != BLOCKS_PER_SECTOR - 1)));
endmodule

// File: rtl/vb_engine.sv
`timescale 1ns/1ps
module vb_engine
    import vb_pkg::*;
#(
    parameter int NUM_SECTORS       = 16,
    parameter int BLOCKS_PER_SECTOR = 4,
    parameter int VALUE_W           = 32,
    localparam int NUM_BLOCKS       = NUM_SECTORS * BLOCKS_PER_SECTOR,
    localparam int BLK_W            = $clog2(NUM_BLOCKS),
    localparam int BLOCK_BITS       = 4 * VALUE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    card_active,
    input  logic [NUM_SECTORS-1:0]  auth_sector,
    input  logic [NUM_BLOCKS*3-1:0] acc_bits,
    input  logic                    frm_valid,
    input  logic [7:0]              frm_cmd,
    input  logic [VALUE_W-1:0]      frm_arg,
    output logic                    rsp_valid,
    output logic [3:0]              rsp_code,
    input  logic                    ld_valid,
    input  logic [BLK_W-1:0]        ld_block,
    input  logic [BLOCK_BITS-1:0]   ld_data,
    input  logic [BLK_W-1:0]        rd_block,
    output logic [BLOCK_BITS-1:0]   rd_data
);
    typedef struct packed {
        phase_e             phase;
        logic [7:0]         op;
        logic [7:0]         blk;
        logic [VALUE_W-1:0] vreg;
        logic               vreg_vld;
        logic               rsp_vld;
        logic [3:0]         rsp_code;
    } state_t;

    state_t s_d, s_q;

    logic [7:0]            eng_addr;
    logic                  permit;
    logic [BLOCK_BITS-1:0] eng_data;
    logic                  fmt_ok, ovf;
    logic [VALUE_W-1:0]    alu_res;
    arith_e                alu_mode;
    logic                  xf_we;
    logic [BLOCK_BITS-1:0] xf_data;
    logic                  dormant;

    assign eng_addr = (s_q.phase == PH_IDLE) ? frm_arg[7:0] : s_q.blk;
    assign dormant  = !card_active || (auth_sector == '0);

    always_comb begin
        case (s_q.op)
            OPC_INC: alu_mode = ARITH_ADD;
            OPC_DEC: alu_mode = ARITH_SUB;
            default: alu_mode = ARITH_PASS;
        endcase
    end

    vb_access_check #(
        .NUM_SECTORS(NUM_SECTORS), .BLOCKS_PER_SECTOR(BLOCKS_PER_SECTOR)
    ) access_i (
        .blk_addr(eng_addr), .auth_sector(auth_sector),
        .acc_bits(acc_bits), .permit(permit)
    );

    vb_value_alu #(.VALUE_W(VALUE_W)) alu_i (
        .blk_data(eng_data), .operand(frm_arg), .mode(alu_mode),
        .fmt_ok(fmt_ok), .result(alu_res), .ovf(ovf)
    );

    assign xf_data = {eng_data[BLOCK_BITS-1:3*VALUE_W], s_q.vreg, ~s_q.vreg, s_q.vreg};

    vb_block_mem #(
        .NUM_BLOCKS(NUM_BLOCKS), .BLOCKS_PER_SECTOR(BLOCKS_PER_SECTOR),
        .BLOCK_BITS(BLOCK_BITS)
    ) mem_i (
        .clk(clk), .rst_n(rst_n),
        .ld_we(ld_valid), .ld_blk(ld_block), .ld_data(ld_data),
        .xf_we(xf_we), .xf_blk(eng_addr[BLK_W-1:0]), .xf_data(xf_data),
        .rda_blk(eng_addr[BLK_W-1:0]), .rda_data(eng_data),
        .rdb_blk(rd_block), .rdb_data(rd_data)
    );

    always_comb begin
        s_d         = s_q;
        s_d.rsp_vld = 1'b0;
        xf_we       = 1'b0;
        if (dormant) begin
            s_d.phase    = PH_IDLE;
            s_d.vreg     = '0;
            s_d.vreg_vld = 1'b0;
        end else if (frm_valid) begin
            if (s_q.phase == PH_IDLE) begin
                s_d.rsp_vld = 1'b1;
                case (frm_cmd)
                    OPC_INC, OPC_DEC, OPC_RST: begin
                        if (!permit)       s_d.rsp_code = RSP_NAK_DENY;
                        else if (!fmt_ok)  s_d.rsp_code = RSP_NAK_BAD;
                        else begin
                            s_d.rsp_code = RSP_ACK;
                            s_d.phase    = PH_OPERAND;
                            s_d.op       = frm_cmd;
                            s_d.blk      = frm_arg[7:0];
                        end
                    end
                    OPC_XFR: begin
                        if (!permit)             s_d.rsp_code = RSP_NAK_DENY;
                        else if (!s_q.vreg_vld)  s_d.rsp_code = RSP_NAK_BAD;
                        else if (!fmt_ok)        s_d.rsp_code = RSP_NAK_BAD;
                        else begin
                            s_d.rsp_code = RSP_ACK;
                            xf_we        = 1'b1;
                        end
                    end
                    default: s_d.rsp_code = RSP_NAK_BAD;
                endcase
            end else begin
                s_d.phase = PH_IDLE;
                if (!permit) begin
                    s_d.rsp_vld  = 1'b1;
                    s_d.rsp_code = RSP_NAK_DENY;
                end else if (!fmt_ok || ovf) begin
                    s_d.rsp_vld  = 1'b1;
                    s_d.rsp_code = RSP_NAK_BAD;
                end else begin
                    s_d.vreg     = alu_res;
                    s_d.vreg_vld = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, op: '0, blk: '0, vreg: '0,
                     vreg_vld: 1'b0, rsp_vld: 1'b0, rsp_code: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_vld;
    assign rsp_code  = s_q.rsp_code;

    // R2
    rsp_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(frm_valid));

    // R12
    vreg_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_active) |=> !s_q.vreg_vld);

    // R6
    xfer_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xf_we |=> (rsp_valid && rsp_code == RSP_ACK));

    // R3
    second_step_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_OPERAND && frm_valid && !dormant) |=>
            (!rsp_valid || rsp_code != RSP_ACK));
endmodule

// File: tb/vb_engine_tb.sv
`timescale 1ns/1ps
module vb_engine_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         card_active = 1'b1;
    logic [15:0]  auth_sector = '1;
    logic [191:0] acc_bits;
    logic         frm_valid = 1'b0;
    logic [7:0]   frm_cmd = '0;
    logic [31:0]  frm_arg = '0;
    logic         rsp_valid;
    logic [3:0]   rsp_code;
    logic         ld_valid = 1'b0;
    logic [5:0]   ld_block = '0;
    logic [127:0] ld_data = '0;
    logic [5:0]   rd_block = '0;
    logic [127:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    vb_engine dut_i (
        .clk(clk), .rst_n(rst_n), .card_active(card_active),
        .auth_sector(auth_sector), .acc_bits(acc_bits),
        .frm_valid(frm_valid), .frm_cmd(frm_cmd), .frm_arg(frm_arg),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .ld_valid(ld_valid), .ld_block(ld_block), .ld_data(ld_data),
        .rd_block(rd_block), .rd_data(rd_data)
    );

    function automatic logic [127:0] mkv(logic [31:0] v, logic [7:0] a);
        return {~a, a, ~a, a, v, ~v, v};
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(int b, logic [127:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_block = 6'(b); ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // Sends one frame; exp_v=0 means no reply is expected.
    task automatic frame(string req, logic [7:0] c, logic [31:0] a, bit exp_v, logic [3:0] exp_c);
        @(negedge clk);
        frm_valid = 1'b1; frm_cmd = c; frm_arg = a;
        @(negedge clk);
        frm_valid = 1'b0;
        chk(req, {127'd0, rsp_valid}, {127'd0, exp_v});
        if (exp_v) chk(req, {124'd0, rsp_code}, {124'd0, exp_c});
    endtask

    task automatic rd_chk(string req, int b, logic [127:0] exp);
        rd_block = 6'(b);
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic pulse_inactive();
        @(negedge clk); card_active = 1'b0;
        @(negedge clk); card_active = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid after reset", {127'd0, rsp_valid}, 128'd0);
        load(4, mkv(100, 4));
        frame("R1 transfer with empty register", 8'hB0, 4, 1, 4'h1);
        rd_chk("R1 block untouched", 4, mkv(100, 4));
    endtask

    task automatic t_restore();
        load(5, mkv(1000, 5));
        load(6, mkv(7, 6));
        frame("R5 restore step1", 8'hC2, 5, 1, 4'hA);
        frame("R5 restore step2 silent", 8'h00, 32'hDEADBEEF, 0, 4'h0);
        rd_chk("R5 source unchanged", 5, mkv(1000, 5));
        frame("R6 transfer ack", 8'hB0, 6, 1, 4'hA);
        rd_chk("R6 transfer writes value keeps addr bytes", 6, mkv(1000, 6));
    endtask

    task automatic t_inc();
        frame("R3 increment step1", 8'hC1, 5, 1, 4'hA);
        frame("R3 increment step2 silent", 8'h00, 25, 0, 4'h0);
        rd_chk("R3 block unchanged before transfer", 5, mkv(1000, 5));
        frame("R3 transfer ack", 8'hB0, 5, 1, 4'hA);
        rd_chk("R3 incremented value", 5, mkv(1025, 5));
    endtask

    task automatic t_dec();
        frame("R4 decrement step1", 8'hC0, 5, 1, 4'hA);
        frame("R4 decrement step2 silent", 8'h00, 2000, 0, 4'h0);
        frame("R4 transfer ack", 8'hB0, 4, 1, 4'hA);
        rd_chk("R4 decremented negative value", 4, mkv(32'd1025 - 32'd2000, 4));
    endtask

    task automatic t_auth();
        auth_sector[1] = 1'b0;
        frame("R7 increment unauthenticated", 8'hC1, 5, 1, 4'h4);
        frame("R7 transfer unauthenticated", 8'hB0, 4, 1, 4'h4);
        rd_chk("R7 block unchanged", 4, mkv(32'd1025 - 32'd2000, 4));
        auth_sector[1] = 1'b1;
    endtask

    task automatic t_access();
        acc_bits[3*6 +: 3] = 3'b000;
        frame("R8 access 000 refused", 8'hC2, 6, 1, 4'h4);
        acc_bits[3*6 +: 3] = 3'b001;
        frame("R8 access 001 accepted", 8'hC2, 6, 1, 4'hA);
        frame("R8 step2 silent", 8'h00, 0, 0, 4'h0);
        acc_bits[3*6 +: 3] = 3'b010;
        frame("R8 access 010 refused on transfer", 8'hB0, 6, 1, 4'h4);
        rd_chk("R8 block unchanged", 6, mkv(1000, 6));
        acc_bits[3*6 +: 3] = 3'b110;
    endtask

    task automatic t_range();
        load(0, mkv(1, 0));
        load(3, mkv(1, 3));
        load(63, mkv(1, 63));
        frame("R9 block 0 refused", 8'hC2, 0, 1, 4'h4);
        frame("R9 transfer to block 0 refused", 8'hB0, 0, 1, 4'h4);
        frame("R9 trailer 3 refused", 8'hC2, 3, 1, 4'h4);
        frame("R9 trailer 63 refused", 8'hC2, 63, 1, 4'h4);
        frame("R9 address 64 refused", 8'hC2, 64, 1, 4'h4);
        load(62, mkv(5, 62));
        frame("R9 block 62 accepted", 8'hC2, 62, 1, 4'hA);
        frame("R9 step2 silent", 8'h00, 0, 0, 4'h0);
    endtask

    task automatic t_format();
        logic [127:0] bad;
        bad = mkv(10, 9);
        bad[95:64] = 32'd11;
        load(9, bad);
        frame("R10 restore malformed", 8'hC2, 9, 1, 4'h1);
        frame("R10 increment malformed", 8'hC1, 9, 1, 4'h1);
        frame("R10 transfer into malformed", 8'hB0, 9, 1, 4'h1);
        rd_chk("R10 malformed block unchanged", 9, bad);
    endtask

    task automatic t_overflow();
        load(10, mkv(32'h7FFFFFFF, 10));
        load(12, mkv(42, 12));
        load(13, mkv(0, 13));
        load(14, mkv(32'h80000000, 14));
        frame("R11 restore step1", 8'hC2, 12, 1, 4'hA);
        frame("R11 restore step2", 8'h00, 0, 0, 4'h0);
        frame("R11 increment step1", 8'hC1, 10, 1, 4'hA);
        frame("R11 increment overflow", 8'h00, 1, 1, 4'h1);
        frame("R11 decrement step1", 8'hC0, 14, 1, 4'hA);
        frame("R11 decrement underflow", 8'h00, 1, 1, 4'h1);
        frame("R11 transfer ack", 8'hB0, 13, 1, 4'hA);
        rd_chk("R11 register kept earlier value", 13, mkv(42, 13));
    endtask

    task automatic t_clear();
        frame("R12 restore step1", 8'hC2, 5, 1, 4'hA);
        frame("R12 restore step2", 8'h00, 0, 0, 4'h0);
        pulse_inactive();
        frame("R12 transfer after deactivation", 8'hB0, 13, 1, 4'h1);
        frame("R12 restore step1 b", 8'hC2, 5, 1, 4'hA);
        frame("R12 restore step2 b", 8'h00, 0, 0, 4'h0);
        @(negedge clk); auth_sector = '0;
        @(negedge clk); auth_sector = '1;
        frame("R12 transfer after auth loss", 8'hB0, 13, 1, 4'h1);
        frame("R12 increment step1 pending", 8'hC1, 5, 1, 4'hA);
        pulse_inactive();
        frame("R12 pending dropped, new command acked", 8'hC2, 5, 1, 4'hA);
        frame("R12 restore step2 c", 8'h00, 0, 0, 4'h0);
        frame("R12 transfer ack", 8'hB0, 13, 1, 4'hA);
        rd_chk("R12 transfer of restored value", 13, mkv(1025, 13));
        @(negedge clk); card_active = 1'b0;
        frame("R12 frame ignored while inactive", 8'hC2, 5, 0, 4'h0);
        card_active = 1'b1;
    endtask

    task automatic t_opcode();
        frame("R2 unknown opcode", 8'h30, 5, 1, 4'h1);
    endtask

    initial begin
        for (int b = 0; b < 64; b++) acc_bits[3*b +: 3] = 3'b110;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_restore();
        t_inc();
        t_dec();
        t_auth();
        t_access();
        t_range();
        t_format();
        t_overflow();
        t_clear();
        t_opcode();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule